// File: doc/BRIEF.md
# Search-Replace Self-Test Pattern Generator and Checker

This block is the on-chip exerciser for a 64-bit search-and-replace datapath. It waits for the datapath to signal that it is ready. It then runs a free-running 16-bit counter and, once in every 512 counts, emits a burst of sixteen 64-bit stimulus words taken from a stored table. The stimulus table holds words that hit a rule and get replaced, and words that miss every rule and pass through. It also holds words whose last byte is a space (0x20), together with the words that follow them.

On the return side, the block compares each valid output word from the datapath with the next entry of a stored expected table. The comparison does not depend on how many cycles the datapath takes or how its output words are spaced. Any difference raises a sticky error. Four registered status lights show that the block is running, the ready input, the error and the live input-valid.

Top module: `stc_selftest`

## Requirements
- R1: While `rst` is high and on the cycle after it, `in_valid_o` is 0, `in_word_o` is zero and all four bits of `ind_o` are 0.
- R2: The 16-bit counter stays at 0 until `ready_i` has been seen high at a clock edge. From the next edge on, it counts by one every cycle. Dropping `ready_i` later does not stop it.
- R3: `in_valid_o` is high in the cycle after the counter holds a value whose bits 8:4 equal 5'b00001. This gives exactly 16 consecutive cycles in every 512 counts. It is low in every other cycle.
- R4: During a burst, `in_word_o` is stimulus entry p, where p is the counter's bits 3:0 that produced that cycle. Outside a burst, `in_word_o` is zero. Entry p has byte 0 (bits 7:0) = 0x61+p, bytes 1..4 = 0x6F, 0x72, 0x73, 0x65, bytes 5 and 6 = 0x00, and byte 7 (bits 63:56) = 0x20 when p mod 4 = 3, otherwise 0x00.
- R5: Expected entry p is the replacement word when p is even, unless p mod 4 = 0 and p is not 0; otherwise it is stimulus entry p unchanged. The replacement word for p is, from byte 0 to byte 7: 0x77, 0x6F, 0x72, 0x64, 0x30, 0x30, 0x30+p, 0x20.
- R6: The expected index starts at 0 after reset. It advances by one, modulo 16, for each cycle in which `out_valid_i` is high, whatever the gaps between valid words.
- R7: A valid output word that differs from its expected entry sets `ind_o[2]` after the second rising edge, counting the edge that samples the word. A matching word never sets it.
- R8: Once set, `ind_o[2]` stays high until reset, regardless of later correct words.
- R9: One cycle after any edge out of reset, `ind_o[0]` is 1. `ind_o[1]` is `ready_i` delayed by one clock. `ind_o[3]` equals `in_valid_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 1 | Datapath reports initialisation complete |
| out_valid_i | input | 1 | Datapath output word is valid |
| out_word_i | input | 64 | Datapath output word |
| in_valid_o | output | 1 | Stimulus word valid |
| in_word_o | output | 64 | Stimulus word to the datapath |
| ind_o | output | 4 | Status lights: 0 running, 1 ready, 2 error, 3 input-valid |

## Verification
A stimulus word appears one edge after the count that selects it. The bench therefore tracks an edge index n from the edge that first sees `ready_i` and expects burst word (n-1) mod 16 whenever (n-1) mod 512 lies in 16..31. It compares every cycle across three bursts, sampling on the falling edge. A returned word goes into the checker at edge X and its error shows after edge X+1, so the bench checks that the light is still off after X and on after X+1. The ready light is checked one edge after `ready_i` changes, and the error light again after a reset.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;

  localparam int WORD_W = 64;

  function automatic logic [WORD_W-1:0] stim_word(input int unsigned p);
    logic [7:0] tail;
    tail = ((p % 4) == 3) ? 8'h20 : 8'h00;
    return {tail, 8'h00, 8'h00, 8'h65, 8'h73, 8'h72, 8'h6F, 8'(8'h61 + p)};
  endfunction

  function automatic logic [WORD_W-1:0] repl_word(input int unsigned p);
    return {8'h20, 8'(8'h30 + p), 8'h30, 8'h30, 8'h64, 8'h72, 8'h6F, 8'h77};
  endfunction

  function automatic logic [WORD_W-1:0] expect_word(input int unsigned p);
    logic hit;
    logic after_space;
    hit         = ((p % 2) == 0);
    after_space = ((p % 4) == 0) && (p != 0);
    return (hit && !after_space) ? repl_word(p) : stim_word(p);
  endfunction

endpackage

// File: rtl/stc_rom.sv
`timescale 1ns/1ps
module stc_rom #(
  parameter int KIND  = 0,
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    if (KIND == 0) begin : g_stim
      assign mem[g] = W'(stc_pkg::stim_word(g));
    end else begin : g_exp
      assign mem[g] = W'(stc_pkg::expect_word(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= mem[addr];
  end
endmodule

// File: rtl/stc_sched.sv
`timescale 1ns/1ps
module stc_sched #(
  parameter int CNT_W    = 16,
  parameter int WIN_LO   = 4,
  parameter int WIN_HI   = 8,
  parameter int WIN_CODE = 1,
  localparam int WIN_W   = WIN_HI - WIN_LO + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  output logic              win_o,
  output logic [WIN_LO-1:0] pos_o,
  output logic              in_valid_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_q | ready_i;
      if (armed_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_o = armed_q && (cnt_q[WIN_HI:WIN_LO] == WIN_W'(WIN_CODE));
  assign pos_o = cnt_q[WIN_LO-1:0];

  always_ff @(posedge clk) begin
    if (rst) in_valid_o <= 1'b0;
    else     in_valid_o <= win_o;
  end

  p_wait_r2: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> cnt_q == '0);
  p_burst_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_valid_o) |-> cnt_q[WIN_HI:0] == (WIN_HI+1)'((WIN_CODE << WIN_LO) + 1));
  p_burst_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(in_valid_o) |-> cnt_q[WIN_HI:0] == (WIN_HI+1)'(((WIN_CODE + 1) << WIN_LO) + 1));
endmodule

// File: rtl/stc_check.sv
`timescale 1ns/1ps
module stc_check #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_valid_i,
  input  logic [W-1:0]  out_word_i,
  input  logic [W-1:0]  exp_q_i,
  output logic [AW-1:0] exp_addr_o,
  output logic          err_o
);
  logic         pipe_v;
  logic [W-1:0] pipe_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_addr_o <= '0;
      pipe_v     <= 1'b0;
      pipe_w     <= '0;
      err_o      <= 1'b0;
    end else begin
      pipe_v <= out_valid_i;
      pipe_w <= out_word_i;
      if (out_valid_i) exp_addr_o <= exp_addr_o + 1'b1;
      if (pipe_v && (pipe_w != exp_q_i)) err_o <= 1'b1;
    end
  end

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid_i |=> exp_addr_o == $past(exp_addr_o) + 1'b1);
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid_i |=> $stable(exp_addr_o));
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (pipe_v && (pipe_w != exp_q_i)) |=> err_o);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: rtl/stc_selftest.sv
`timescale 1ns/1ps
module stc_selftest #(
  parameter int CNT_W    = 16,
  parameter int WIN_LO   = 4,
  parameter int WIN_HI   = 8,
  parameter int WIN_CODE = 1,
  localparam int W       = stc_pkg::WORD_W,
  localparam int DEPTH   = 1 << WIN_LO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ready_i,
  input  logic         out_valid_i,
  input  logic [W-1:0] out_word_i,
  output logic         in_valid_o,
  output logic [W-1:0] in_word_o,
  output logic [3:0]   ind_o
);
  logic              win;
  logic [WIN_LO-1:0] pos;
  logic [WIN_LO-1:0] exp_addr;
  logic [W-1:0]      exp_q;
  logic              err;
  logic              run_q;
  logic              rdy_q;

  stc_sched #(.CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .WIN_CODE(WIN_CODE)) u_sched (
    .clk(clk), .rst(rst), .ready_i(ready_i),
    .win_o(win), .pos_o(pos), .in_valid_o(in_valid_o));

  stc_rom #(.KIND(0), .DEPTH(DEPTH), .W(W)) u_stim (
    .clk(clk), .rst(rst), .en(1'b1), .clr(!win), .addr(pos), .q(in_word_o));

  stc_rom #(.KIND(1), .DEPTH(DEPTH), .W(W)) u_exp (
    .clk(clk), .rst(rst), .en(out_valid_i), .clr(1'b0), .addr(exp_addr), .q(exp_q));

  stc_check #(.W(W), .DEPTH(DEPTH)) u_check (
    .clk(clk), .rst(rst), .out_valid_i(out_valid_i), .out_word_i(out_word_i),
    .exp_q_i(exp_q), .exp_addr_o(exp_addr), .err_o(err));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      rdy_q <= ready_i;
    end
  end

  assign ind_o = {in_valid_o, err, rdy_q, run_q};

  p_word_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid_o |-> in_word_o == '0);
  p_ready_lamp_r9: assert property (@(posedge clk) disable iff (rst)
    ready_i |=> ind_o[1]);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ind_o == 4'b0) && !in_valid_o);
endmodule

// File: tb/tb_stc_selftest.sv
`timescale 1ns/1ps
module tb_stc_selftest;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ready_i = 1'b0;
  logic        out_valid_i = 1'b0;
  logic [63:0] out_word_i = '0;
  logic        in_valid_o;
  logic [63:0] in_word_o;
  logic [3:0]  ind_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  stc_selftest dut (.*);

  always #10 clk = ~clk;

  function automatic logic [63:0] m_stim(int p);
    logic [7:0] t;
    t = (p % 4 == 3) ? 8'h20 : 8'h00;
    return {t, 16'h0000, 8'h65, 8'h73, 8'h72, 8'h6F, 8'(8'h61 + p)};
  endfunction

  function automatic logic [63:0] m_exp(int p);
    if (p % 2 == 0 && !(p % 4 == 0 && p != 0))
      return {8'h20, 8'(8'h30 + p), 8'h30, 8'h30, 8'h64, 8'h72, 8'h6F, 8'h77};
    return m_stim(p);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(logic [63:0] w, int gap);
    out_valid_i = 1'b1;
    out_word_i  = w;
    @(negedge clk);
    out_valid_i = 1'b0;
    out_word_i  = '0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", 64'(in_valid_o), 0);
    chk("R1 word", in_word_o, 0);
    chk("R1 ind", 64'(ind_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 run lamp", 64'(ind_o[0]), 1);
    // R2: no bursts while ready stays low (600 cycles spans a full period)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chk("R2 idle", 64'(in_valid_o), 0);
    end
    chk("R9 ready lamp low", 64'(ind_o[1]), 0);
    ready_i = 1'b1;
    for (int n = 0; n < 1200; n++) begin
      logic ev;
      @(negedge clk);
      ev = (n >= 1) && (((n - 1) % 512) >= 16) && (((n - 1) % 512) <= 31);
      chk("R3 valid", 64'(in_valid_o), 64'(ev));
      chk("R4 word", in_word_o, ev ? m_stim((n - 1) % 16) : 64'h0);
      chk("R9 ind3", 64'(ind_o[3]), 64'(in_valid_o));
      chk("R9 ind0", 64'(ind_o[0]), 1);
      chk("R9 ind1", 64'(ind_o[1]), (n <= 600) ? 64'h1 : 64'h0);
      if (n == 600) ready_i = 1'b0;
    end
    // R5 R6: two full passes with uneven gaps, no error
    for (int i = 0; i < 32; i++) send(m_exp(i % 16), i % 3);
    @(negedge clk);
    chk("R6 R5 clean", 64'(ind_o[2]), 0);
    // R7: bad word at index 0, timing of flag
    out_valid_i = 1'b1;
    out_word_i  = m_exp(0) ^ 64'h1;
    @(negedge clk);
    out_valid_i = 1'b0;
    chk("R7 not yet", 64'(ind_o[2]), 0);
    @(negedge clk);
    chk("R7 flag", 64'(ind_o[2]), 1);
    // R8: correct words do not clear it
    for (int i = 1; i < 8; i++) send(m_exp(i), 1);
    chk("R8 sticky", 64'(ind_o[2]), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 err cleared", 64'(ind_o), 0);
    rst = 1'b0;
    // R6: index restarted at 0 after reset
    for (int i = 0; i < 6; i++) send(m_exp(i), 0);
    @(negedge clk);
    chk("R6 restart", 64'(ind_o[2]), 0);
    // R7: a pass-through word sent where a replacement is due
    send(m_stim(6), 0);
    @(negedge clk);
    chk("R7 replaced mismatch", 64'(ind_o[2]), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule